// File: doc/BRIEF.md
# Vector Instruction Issue Controller

This block sits between one scalar core and a pool of vector lanes. The core sends 32-bit vector instructions over a valid/ready stream. The controller accepts each instruction into a decode stage. There it checks the instruction's registers against a scoreboard of outstanding writes. A second stage maps the architectural register numbers onto physical ones. That stage also takes a free 4-bit tag and broadcasts the instruction to every lane that the scheduler has assigned to this controller.

Each lane reports completion by tag on its own done strobe. The controller keeps one pending-lane set per tag. It retires a tag, freeing the tag and the register it wrote, only when every lane that received the instruction has reported it.

When the lanes are shared at fine grain between two cores, each core's register numbers land in a separate physical bank. Instructions from both cores can then interleave in the same lanes without sharing a register. The scheduler can withhold issue altogether by dropping the issue-enable input.

Top module: `vector_issue_ctrl`

## Requirements
- R1: After reset the controller is ready to accept an instruction, drives no lane push and reports no retirement.
- R2: Instruction word layout: opcode in bits 31:28, destination register in 27:25, source A in 24:22, source B in 21:19 and element count in 7:0. An instruction accepted at one clock edge is pushed during the cycle that follows the next edge. The push lasts one cycle and carries the opcode, the element count and the tag.
- R3: The push goes exactly to the lanes set in the lane-assignment mask, sampled when the instruction leaves decode.
- R4: A tag is reported retired only after every lane that received it has raised its done strobe with that tag. A report from a subset of those lanes does not retire it.
- R5: Physical register number = {bank, architectural number}. The bank is the core-select input when fine-grain sharing is on, and 0 when it is off. This mapping applies to the destination and to both sources.
- R6: No lane is pushed while issue-enable is low. The instruction waits in the issue stage and is pushed in the cycle that issue-enable rises.
- R7: No push happens while any assigned lane reports its FIFO full. A full flag from a lane outside the assigned set has no effect.
- R8: An instruction whose source or destination physical register is the destination of an outstanding instruction is not issued until that instruction retires.
- R9: An instruction with opcode bit 31 set is a store. It writes no register, so it places no register busy.
- R10: A tag is allocated as the lowest-numbered free tag. With all 16 tags outstanding, issue stalls and input readiness drops until a tag retires.
- R11: At most one tag retires per cycle, the lowest-numbered complete one first. A retired tag is reported once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word valid from the core |
| inData | input | 32 | Instruction word |
| inReady | output | 1 | Controller accepts the word this cycle |
| shareFine | input | 1 | Fine-grain sharing on: rename into the core's bank |
| coreSel | input | 1 | Identity of the attached core (bank number) |
| issueEnable | input | 1 | Sharing context allows this controller to issue |
| laneMask | input | NUM_LANES | Lanes assigned to this controller |
| laneFifoFull | input | NUM_LANES | Per-lane instruction FIFO full |
| laneDoneValid | input | NUM_LANES | Per-lane completion strobe |
| laneDoneTag | input | 4*NUM_LANES | Per-lane completed tag, lane l in bits 4l+3:4l |
| lanePush | output | NUM_LANES | Per-lane FIFO push |
| pushTag | output | 4 | Tag of the pushed instruction |
| pushOp | output | 4 | Opcode |
| pushDst | output | 4 | Physical destination register |
| pushSrcA | output | 4 | Physical source A register |
| pushSrcB | output | 4 | Physical source B register |
| pushLen | output | 8 | Element count |
| retireValid | output | 1 | A tag retires this cycle |
| retireTag | output | 4 | Retiring tag |

## Verification
A stuck bit in a tag's pending-lane set shows up as a retirement that never comes, or one that arrives one done-strobe early. Either way it is visible on the retire port in the cycle after the relevant lane reports. A scoreboard bit that is left set or cleared too soon appears as a dependent instruction that is never pushed, or one pushed while its producer is still outstanding. This shows on the push strobes a few cycles after the dependent instruction is accepted. A wrong free-tag pick shows directly on the push tag, and a wrong bank bit shows in the physical register fields of that same push.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int TAG_W    = 4;
  localparam int NUM_TAGS = 1 << TAG_W;

  typedef logic [TAG_W-1:0] tag_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadS1;     // capture incoming word into decode stage
    logic advance;    // decode stage moves to issue stage, tag allocated
    logic retire;     // a tag retires this cycle
    tag_t allocTag;
    tag_t retireTag;
  } vic_strobe_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int OP_W    = 4,
  parameter int ARCH_W  = 3,
  parameter int LEN_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [INSTR_W-1:0]  inData,
  input  logic                shareFine,
  input  logic                coreSel,
  input  vic_strobe_t         stb,
  output logic                hazard,
  output logic [OP_W-1:0]     pushOp,
  output logic [ARCH_W:0]     pushDst,
  output logic [ARCH_W:0]     pushSrcA,
  output logic [ARCH_W:0]     pushSrcB,
  output logic [LEN_W-1:0]    pushLen,
  output tag_t                pushTag
);
  localparam int PREG_W    = ARCH_W + 1;
  localparam int NUM_PREGS = 1 << PREG_W;
  localparam int OP_LSB    = INSTR_W - OP_W;
  localparam int DST_LSB   = OP_LSB - ARCH_W;
  localparam int SRCA_LSB  = DST_LSB - ARCH_W;
  localparam int SRCB_LSB  = SRCA_LSB - ARCH_W;

  logic [INSTR_W-1:0]   s1Instr;
  logic [OP_W-1:0]      s1Op;
  logic                 s1Wr;
  logic                 bank;
  logic [PREG_W-1:0]    pDst, pSrcA, pSrcB;
  logic [NUM_PREGS-1:0] busy, busyNext;
  logic [PREG_W-1:0]    tagDst [NUM_TAGS];
  logic [NUM_TAGS-1:0]  tagWr;
  logic                 unusedRsvd;

  // Decode and rename of the word held in the decode stage
  assign s1Op       = s1Instr[OP_LSB +: OP_W];
  assign s1Wr       = ~s1Op[OP_W-1];
  assign bank       = shareFine & coreSel;
  assign pDst       = {bank, s1Instr[DST_LSB  +: ARCH_W]};
  assign pSrcA      = {bank, s1Instr[SRCA_LSB +: ARCH_W]};
  assign pSrcB      = {bank, s1Instr[SRCB_LSB +: ARCH_W]};
  assign unusedRsvd = ^s1Instr[SRCB_LSB-1:LEN_W];

  assign hazard = busy[pDst] | busy[pSrcA] | busy[pSrcB];

  always_comb begin
    busyNext = busy;
    if (stb.retire && tagWr[stb.retireTag]) busyNext[tagDst[stb.retireTag]] = 1'b0;
    if (stb.advance && s1Wr)                busyNext[pDst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Instr  <= '0;
      busy     <= '0;
      tagWr    <= '0;
      pushOp   <= '0;
      pushDst  <= '0;
      pushSrcA <= '0;
      pushSrcB <= '0;
      pushLen  <= '0;
      pushTag  <= '0;
      for (int t = 0; t < NUM_TAGS; t++) tagDst[t] <= '0;
    end else begin
      busy <= busyNext;
      if (stb.loadS1) s1Instr <= inData;
      if (stb.advance) begin
        pushOp                <= s1Op;
        pushDst               <= pDst;
        pushSrcA              <= pSrcA;
        pushSrcB              <= pSrcB;
        pushLen               <= s1Instr[LEN_W-1:0];
        pushTag               <= stb.allocTag;
        tagDst[stb.allocTag]  <= pDst;
        tagWr[stb.allocTag]   <= s1Wr;
      end
    end
  end
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic                       issueEnable,
  input  logic [NUM_LANES-1:0]       laneMask,
  input  logic [NUM_LANES-1:0]       laneFifoFull,
  input  logic [NUM_LANES-1:0]       laneDoneValid,
  input  logic [NUM_LANES*TAG_W-1:0] laneDoneTag,
  input  logic                       hazard,
  output logic                       inReady,
  output logic [NUM_LANES-1:0]       lanePush,
  output logic                       retireValid,
  output tag_t                       retireTag,
  output vic_strobe_t                stb
);
  logic                 s1Valid, s2Valid;
  logic [NUM_LANES-1:0] s2Mask;
  logic [NUM_TAGS-1:0]  tagBusy;
  logic [NUM_LANES-1:0] pend [NUM_TAGS];
  logic                 tagAvail, leave, advance;
  tag_t                 allocTag;

  // Lowest free tag, lowest complete tag
  always_comb begin
    tagAvail    = 1'b0;
    allocTag    = '0;
    retireValid = 1'b0;
    retireTag   = '0;
    for (int t = NUM_TAGS-1; t >= 0; t--) begin
      if (!tagBusy[t]) begin
        tagAvail = 1'b1;
        allocTag = TAG_W'(t);
      end
      if (tagBusy[t] && pend[t] == '0) begin
        retireValid = 1'b1;
        retireTag   = TAG_W'(t);
      end
    end
  end

  assign leave    = s2Valid & issueEnable & ~|(s2Mask & laneFifoFull);
  assign advance  = s1Valid & ~hazard & tagAvail & (|laneMask) & (~s2Valid | leave);
  assign inReady  = ~s1Valid | advance;
  assign lanePush = leave ? s2Mask : '0;

  assign stb.loadS1    = inValid & inReady;
  assign stb.advance   = advance;
  assign stb.retire    = retireValid;
  assign stb.allocTag  = allocTag;
  assign stb.retireTag = retireTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
      s2Mask  <= '0;
      tagBusy <= '0;
      for (int t = 0; t < NUM_TAGS; t++) pend[t] <= '0;
    end else begin
      if (stb.loadS1)   s1Valid <= 1'b1;
      else if (advance) s1Valid <= 1'b0;
      if (advance)      s2Valid <= 1'b1;
      else if (leave)   s2Valid <= 1'b0;
      for (int t = 0; t < NUM_TAGS; t++)
        for (int l = 0; l < NUM_LANES; l++)
          if (laneDoneValid[l] && laneDoneTag[l*TAG_W +: TAG_W] == TAG_W'(t))
            pend[t][l] <= 1'b0;
      if (retireValid) tagBusy[retireTag] <= 1'b0;
      if (advance) begin
        s2Mask           <= laneMask;
        pend[allocTag]   <= laneMask;
        tagBusy[allocTag] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vector_issue_ctrl.sv
module vector_issue_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int INSTR_W   = 32,
  parameter int OP_W      = 4,
  parameter int ARCH_W    = 3,
  parameter int LEN_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [INSTR_W-1:0]         inData,
  output logic                       inReady,
  input  logic                       shareFine,
  input  logic                       coreSel,
  input  logic                       issueEnable,
  input  logic [NUM_LANES-1:0]       laneMask,
  input  logic [NUM_LANES-1:0]       laneFifoFull,
  input  logic [NUM_LANES-1:0]       laneDoneValid,
  input  logic [NUM_LANES*TAG_W-1:0] laneDoneTag,
  output logic [NUM_LANES-1:0]       lanePush,
  output logic [TAG_W-1:0]           pushTag,
  output logic [OP_W-1:0]            pushOp,
  output logic [ARCH_W:0]            pushDst,
  output logic [ARCH_W:0]            pushSrcA,
  output logic [ARCH_W:0]            pushSrcB,
  output logic [LEN_W-1:0]           pushLen,
  output logic                       retireValid,
  output logic [TAG_W-1:0]           retireTag
);
  vic_strobe_t stb;
  logic        hazard;

  vic_control #(.NUM_LANES(NUM_LANES)) i_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .issueEnable(issueEnable),
    .laneMask(laneMask), .laneFifoFull(laneFifoFull),
    .laneDoneValid(laneDoneValid), .laneDoneTag(laneDoneTag),
    .hazard(hazard), .inReady(inReady), .lanePush(lanePush),
    .retireValid(retireValid), .retireTag(retireTag), .stb(stb)
  );

  vic_datapath #(.INSTR_W(INSTR_W), .OP_W(OP_W), .ARCH_W(ARCH_W), .LEN_W(LEN_W)) i_datapath (
    .clk(clk), .rstN(rstN), .inData(inData), .shareFine(shareFine), .coreSel(coreSel),
    .stb(stb), .hazard(hazard), .pushOp(pushOp), .pushDst(pushDst),
    .pushSrcA(pushSrcA), .pushSrcB(pushSrcB), .pushLen(pushLen), .pushTag(pushTag)
  );
endmodule

// File: rtl/vector_issue_ctrl_chk.sv
module vector_issue_ctrl_chk #(
  parameter int NUM_LANES = 4,
  parameter int ARCH_W    = 3,
  parameter int TAG_W     = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueEnable,
  input logic                 shareFine,
  input logic                 coreSel,
  input logic [NUM_LANES-1:0] laneFifoFull,
  input logic [NUM_LANES-1:0] lanePush,
  input logic [TAG_W-1:0]     pushTag,
  input logic [ARCH_W:0]      pushDst,
  input logic                 retireValid,
  input logic [TAG_W-1:0]     retireTag
);
  AST_PUSH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (|lanePush) |-> issueEnable);                                            // R6
  AST_NO_PUSH_INTO_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (|lanePush) |-> ((lanePush & laneFifoFull) == '0));                       // R7
  AST_RENAME_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (|lanePush) |-> (pushDst[ARCH_W] == (shareFine & coreSel)));              // R5
  AST_RETIRE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |=> !(retireValid && retireTag == $past(retireTag)));        // R11
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    (|lanePush) |=> !((|lanePush) && pushTag == $past(pushTag)));            // R10
endmodule

bind vector_issue_ctrl vector_issue_ctrl_chk #(
  .NUM_LANES(NUM_LANES), .ARCH_W(ARCH_W), .TAG_W(vic_pkg::TAG_W)
) i_chk (
  .clk(clk), .rstN(rstN), .issueEnable(issueEnable), .shareFine(shareFine),
  .coreSel(coreSel), .laneFifoFull(laneFifoFull), .lanePush(lanePush),
  .pushTag(pushTag), .pushDst(pushDst), .retireValid(retireValid),
  .retireTag(retireTag)
);

// File: tb/test_vector_issue_ctrl.sv
module test_vector_issue_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_LANES  = 4;

  logic                     clk = 1'b0;
  logic                     rstN;
  logic                     inValid;
  logic [31:0]              inData;
  logic                     inReady;
  logic                     shareFine, coreSel, issueEnable;
  logic [NUM_LANES-1:0]     laneMask, laneFifoFull, laneDoneValid;
  logic [NUM_LANES*4-1:0]   laneDoneTag;
  logic [NUM_LANES-1:0]     lanePush;
  logic [3:0]               pushTag, pushOp, pushDst, pushSrcA, pushSrcB;
  logic [7:0]               pushLen;
  logic                     retireValid;
  logic [3:0]               retireTag;

  int total = 0;
  int bad   = 0;
  int pushCount = 0;
  logic [3:0] lastTag, lastSrcA;

  vector_issue_ctrl #(.NUM_LANES(NUM_LANES)) i_vector_issue_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .shareFine(shareFine), .coreSel(coreSel), .issueEnable(issueEnable),
    .laneMask(laneMask), .laneFifoFull(laneFifoFull),
    .laneDoneValid(laneDoneValid), .laneDoneTag(laneDoneTag),
    .lanePush(lanePush), .pushTag(pushTag), .pushOp(pushOp), .pushDst(pushDst),
    .pushSrcA(pushSrcA), .pushSrcB(pushSrcB), .pushLen(pushLen),
    .retireValid(retireValid), .retireTag(retireTag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rstN && |lanePush) begin
      pushCount++;
      lastTag  = pushTag;
      lastSrcA = pushSrcA;
    end
  end

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [2:0] d,
                                     input logic [2:0] a, input logic [2:0] b,
                                     input logic [7:0] len);
    return {op, d, a, b, 11'b0, len};
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic share, input logic core, input logic en,
                         input logic [NUM_LANES-1:0] mask, input logic [NUM_LANES-1:0] full);
    rstN = 1'b0; inValid = 1'b0; inData = '0;
    shareFine = share; coreSel = core; issueEnable = en;
    laneMask = mask; laneFifoFull = full; laneDoneValid = '0; laneDoneTag = '0;
    tick(); tick();
    rstN = 1'b1;
    tick();
    pushCount = 0;
  endtask

  task automatic sendInstr(input logic [31:0] w);
    inValid = 1'b1;
    inData  = w;
    while (!inReady) tick();
    tick();
    inValid = 1'b0;
  endtask

  task automatic doneDrive(input logic [NUM_LANES-1:0] v, input logic [NUM_LANES*4-1:0] tags);
    laneDoneValid = v;
    laneDoneTag   = tags;
    tick();
    laneDoneValid = '0;
  endtask

  task automatic testReset();
    doReset(1'b0, 1'b0, 1'b1, 4'b0001, 4'b0000);
    check("R1 inReady", inReady, 1);
    check("R1 lanePush", lanePush, 0);
    check("R1 retireValid", retireValid, 0);
  endtask

  task automatic testIssueAndComplete();
    doReset(1'b0, 1'b1, 1'b1, 4'b0101, 4'b0000);
    sendInstr(mk(4'd1, 3'd3, 3'd1, 3'd2, 8'd20));
    check("R2 no early push", lanePush, 0);
    tick();
    check("R3 push mask", lanePush, 4'b0101);
    check("R2 tag", pushTag, 0);
    check("R2 op", pushOp, 1);
    check("R2 len", pushLen, 20);
    check("R5 coarse dst", pushDst, 3);
    check("R5 coarse srcA", pushSrcA, 1);
    check("R5 coarse srcB", pushSrcB, 2);
    tick();
    check("R2 single push", lanePush, 0);
    doneDrive(4'b0001, 16'h0000);
    check("R4 partial not retired", retireValid, 0);
    doneDrive(4'b0100, 16'h0000);
    check("R4 all lanes retire", retireValid, 1);
    check("R4 retire tag", retireTag, 0);
    tick();
    check("R11 retire once", retireValid, 0);
  endtask

  task automatic testRename();
    doReset(1'b1, 1'b1, 1'b1, 4'b0010, 4'b0000);
    sendInstr(mk(4'd2, 3'd2, 3'd4, 3'd5, 8'd4));
    tick();
    check("R5 fine dst", pushDst, 4'd10);
    check("R5 fine srcA", pushSrcA, 4'd12);
    check("R5 fine srcB", pushSrcB, 4'd13);
  endtask

  task automatic testIssueEnable();
    doReset(1'b0, 1'b0, 1'b0, 4'b0001, 4'b0000);
    sendInstr(mk(4'd1, 3'd1, 3'd0, 3'd0, 8'd1));
    tick(); tick(); tick();
    check("R6 held while disabled", lanePush, 0);
    check("R6 no push counted", pushCount, 0);
    issueEnable = 1'b1;
    #1;
    check("R6 push on enable", lanePush, 4'b0001);
    tick();
    check("R6 push ends", lanePush, 0);
  endtask

  task automatic testFifoFull();
    doReset(1'b0, 1'b0, 1'b1, 4'b0011, 4'b0010);
    sendInstr(mk(4'd1, 3'd1, 3'd0, 3'd0, 8'd1));
    tick(); tick();
    check("R7 stall on full", lanePush, 0);
    laneFifoFull = 4'b0100;
    #1;
    check("R7 outside lane ignored", lanePush, 4'b0011);
  endtask

  task automatic testHazard();
    doReset(1'b0, 1'b0, 1'b1, 4'b0001, 4'b0000);
    sendInstr(mk(4'd1, 3'd1, 3'd0, 3'd0, 8'd1));
    sendInstr(mk(4'd2, 3'd4, 3'd1, 3'd0, 8'd1));
    tick(); tick(); tick();
    check("R8 dependent held", pushCount, 1);
    doneDrive(4'b0001, 16'h0000);
    tick(); tick(); tick(); tick();
    check("R8 dependent issued", pushCount, 2);
    check("R8 reader srcA", lastSrcA, 1);
    check("R10 freed tag reused", lastTag, 0);
  endtask

  task automatic testStore();
    doReset(1'b0, 1'b0, 1'b1, 4'b0001, 4'b0000);
    sendInstr(mk(4'd8, 3'd1, 3'd0, 3'd0, 8'd1));
    sendInstr(mk(4'd1, 3'd2, 3'd1, 3'd1, 8'd1));
    tick(); tick();
    check("R9 store leaves reg free", pushCount, 2);
    check("R9 second tag", lastTag, 1);
  endtask

  task automatic testTagExhaust();
    doReset(1'b0, 1'b0, 1'b1, 4'b0001, 4'b0000);
    for (int i = 0; i < 16; i++) sendInstr(mk(4'd8, 3'd0, 3'd0, 3'd0, 8'd1));
    tick(); tick();
    check("R10 sixteen issued", pushCount, 16);
    check("R10 last tag", lastTag, 15);
    sendInstr(mk(4'd8, 3'd0, 3'd0, 3'd0, 8'd1));
    tick(); tick(); tick();
    check("R10 stall without tag", pushCount, 16);
    check("R10 not ready", inReady, 0);
    doneDrive(4'b0001, 16'h0005);
    tick(); tick(); tick(); tick();
    check("R10 issued after retire", pushCount, 17);
    check("R10 lowest free tag", lastTag, 5);
  endtask

  task automatic testRetireOrder();
    doReset(1'b0, 1'b0, 1'b1, 4'b0011, 4'b0000);
    for (int i = 0; i < 3; i++) sendInstr(mk(4'd8, 3'd0, 3'd0, 3'd0, 8'd1));
    tick(); tick();
    doneDrive(4'b0011, 16'h0010);
    check("R4 crossed lanes pending", retireValid, 0);
    doneDrive(4'b0011, 16'h0001);
    check("R11 first retire valid", retireValid, 1);
    check("R11 lowest first", retireTag, 0);
    tick();
    check("R11 second retire valid", retireValid, 1);
    check("R11 second tag", retireTag, 1);
    tick();
    check("R11 tag2 still pending", retireValid, 0);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    testReset();
    testIssueAndComplete();
    testRename();
    testIssueEnable();
    testFifoFull();
    testHazard();
    testStore();
    testTagExhaust();
    testRetireOrder();
    finishRun();
  end
endmodule